// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It runs on a system clock. It samples the bus clock and data lines through synchronisers and recognises START and STOP conditions from those samples. It answers a fixed device-type code and serves a 256-byte array that it holds in registers. The host can write a single byte, or write up to a page of sixteen bytes in one burst. It can read from the current pointer, from an address it chooses, or as a continuous stream.

Writes are not applied while they arrive. They collect in a sixteen-slot page buffer. A STOP condition commits the buffer to the array in one step and starts a countdown that models the nonvolatile programming time. During that countdown the block refuses its own address. A host can therefore poll for completion by sending the device address until it is acknowledged.

Two inputs gate memory access. A write-protect input refuses data bytes. A supervisory reset-active input drops any transfer in progress and accepts no new ones, but it never cuts short a programming countdown that has already begun. The block drives the data line only through an open-drain enable.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The first byte after a START is acknowledged (SDA held low for the ninth clock) only when its upper four bits equal the DEV_ID parameter, default 4'b1010. Bit 0 of that byte selects read when 1 and write when 0. A byte with a different upper nibble gets no acknowledge.
- R2: In a write transfer, the byte after the device byte loads the 8-bit word pointer and is acknowledged. Every data byte after it is acknowledged and becomes readable at its address once the transfer ends with a STOP.
- R3: During a write burst only the low four pointer bits advance after each data byte, and the upper four stay fixed. A seventeenth or later byte overwrites the earlier byte at the same position in that page. No location outside the page is changed.
- R4: Programming begins only on a STOP, and only if at least one data byte was accepted after the word address. A STOP right after the word address leaves busy_o low.
- R5: busy_o goes high when programming begins and stays high for PROG_CYCLES clocks (default 400). While busy_o is high the device byte gets no acknowledge. Once busy_o is low again, the same byte is acknowledged.
- R6: A read that starts right after the device byte returns the byte at the pointer, which holds the last accessed address plus one.
- R7: A dummy write of a word address, followed by a repeated START and a read device byte, returns the byte at that address.
- R8: In a read, each host acknowledge brings the byte at the next address. The pointer advances across all 8 bits and wraps from 255 to 0.
- R9: After the host declines to acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R10: While wp_i is high, the device and word address bytes are still acknowledged. Every data byte gets no acknowledge, and nothing is programmed.
- R11: While rst_act_i is high, SDA is released within one clock, the transfer in progress is dropped without programming, and no device byte is acknowledged.
- R12: A programming countdown that has begun runs to its end even while rst_act_i is high.
- R13: The SDA enable changes only while SCL is low.
- R14: After rst_ni the SDA enable and busy_o are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| wp_i | input | 1 | Write protect, high refuses data bytes |
| rst_act_i | input | 1 | Supervisory reset active, aborts bus traffic |
| sda_oe_o | output | 1 | High pulls the data line low |
| busy_o | output | 1 | Programming countdown running |

## Verification
The writes are tried in several shapes, and each shape separates a different fault. A single byte and an eighteen-byte burst that starts mid-page show whether the pointer wraps inside the page or carries into the next page. A read that continues one byte past the page shows that nothing leaked outside it. Reads are tried three ways: from a chosen address, from the current pointer, and as a stream that crosses from 255 to 0. Together these show whether the pointer advances over the full 8 bits on reads, and only over the low nibble on writes. Protected writes, a STOP straight after the word address, and aborts by the reset-active input are each followed by a read-back. Each read-back shows whether the refused or dropped data reached the array or started a countdown.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDAT,
    ST_RDAT,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edge while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYCLES = 400,
  parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (go_i && cnt_q == '0) cnt_q <= CNT_W'(PROG_CYCLES);
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem_q     [DEPTH];
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [SLOTS-1:0]  slot_vld;
  logic [ROW_W-1:0]  row_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i || commit_i) begin
        vld_q <= 1'b0;
      end else if (wr_i && wr_addr_i[PAGE_W-1:0] == PAGE_W'(s)) begin
        byte_q <= wr_data_i;
        vld_q  <= 1'b1;
      end
    end
    assign slot_data[s] = byte_q;
    assign slot_vld[s]  = vld_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   row_q <= '0;
    else if (wr_i) row_q <= wr_addr_i[ADDR_W-1:PAGE_W];
  end

  // whole page lands in one clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int s = 0; s < SLOTS; s++)
        if (slot_vld[s]) mem_q[{row_q, PAGE_W'(s)}] <= slot_data[s];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              hold_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              clr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              sda_oe_o,
  output slv_state_e        state_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              ack_ph_q, oe_q, pend_q, rw_q, mack_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      oe_q      <= 1'b0;
      pend_q    <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sh_q      <= '0;
      ptr_q     <= '0;
      clr_o     <= 1'b0;
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      clr_o <= 1'b0;
      wr_o  <= 1'b0;
      if (hold_i) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        pend_q    <= 1'b0;
        ack_ph_q  <= 1'b0;
        bit_cnt_q <= '0;
      end else if (start_i) begin
        state_q   <= ST_DEV;
        oe_q      <= 1'b0;
        pend_q    <= 1'b0;
        ack_ph_q  <= 1'b0;
        bit_cnt_q <= '0;
        clr_o     <= 1'b1;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        pend_q   <= 1'b0;
        ack_ph_q <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_WORD, ST_WDAT: begin
            if (scl_rise_i && bit_cnt_q < FULL) begin
              sh_q      <= {sh_q[DATA_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == FULL && !ack_ph_q) begin
              ack_ph_q <= 1'b1;
              if (state_q == ST_DEV) begin
                if (sh_q[DATA_W-1:DATA_W-4] == DEV_ID && !busy_i) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (state_q == ST_WORD) begin
                oe_q  <= 1'b1;
                ptr_q <= ADDR_W'(sh_q);
              end else if (wp_i) begin
                state_q <= ST_WAIT;
                pend_q  <= 1'b0;
              end else begin
                oe_q      <= 1'b1;
                wr_o      <= 1'b1;
                wr_addr_o <= ptr_q;
                wr_data_o <= sh_q;
                pend_q    <= 1'b1;
                ptr_q     <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
              end
            end else if (scl_fall_i && ack_ph_q) begin
              ack_ph_q  <= 1'b0;
              bit_cnt_q <= '0;
              oe_q      <= 1'b0;
              if (state_q == ST_DEV) begin
                if (rw_q) begin
                  state_q <= ST_RDAT;
                  sh_q    <= rd_data_i;
                  oe_q    <= ~rd_data_i[DATA_W-1];
                  ptr_q   <= ptr_q + 1'b1;
                end else begin
                  state_q <= ST_WORD;
                end
              end else if (state_q == ST_WORD) begin
                state_q <= ST_WDAT;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise_i) begin
              if (bit_cnt_q < FULL) bit_cnt_q <= bit_cnt_q + 1'b1;
              else if (ack_ph_q)    mack_q    <= ~sda_i;
            end else if (scl_fall_i) begin
              if (ack_ph_q) begin
                ack_ph_q <= 1'b0;
                if (mack_q) begin
                  sh_q      <= rd_data_i;
                  oe_q      <= ~rd_data_i[DATA_W-1];
                  ptr_q     <= ptr_q + 1'b1;
                  bit_cnt_q <= '0;
                end else begin
                  state_q <= ST_WAIT;
                  oe_q    <= 1'b0;
                end
              end else if (bit_cnt_q == FULL) begin
                oe_q     <= 1'b0;
                ack_ph_q <= 1'b1;
                mack_q   <= 1'b0;
              end else if (bit_cnt_q != '0) begin
                sh_q <= sh_q << 1;
                oe_q <= ~sh_q[DATA_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign commit_o  = stop_i & pend_q & ~hold_i;
  assign rd_addr_o = ptr_q;
  assign sda_oe_o  = oe_q;
  assign state_o   = state_q;
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         PROG_CYCLES = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  input  logic rst_act_i,
  output logic sda_oe_o,
  output logic busy_o
);
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              buf_clr, buf_wr, commit;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  prog_cnt;
  slv_state_e        state;

  i2c_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_evt),
    .stop_o    (stop_evt)
  );

  i2c_slave_fsm #(
    .DEV_ID(DEV_ID), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_evt),
    .stop_i    (stop_evt),
    .wp_i      (wp_i),
    .hold_i    (rst_act_i),
    .busy_i    (busy_o),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .clr_o     (buf_clr),
    .wr_o      (buf_wr),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .commit_o  (commit),
    .sda_oe_o  (sda_oe_o),
    .state_o   (state)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (buf_clr),
    .wr_i     (buf_wr),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .commit_i (commit),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (commit),
    .cnt_o (prog_cnt),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk
  import i2c_eeprom_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_act_i,
  input logic             sda_oe_o,
  input logic             busy_o,
  input logic             scl_s,
  input logic             stop_evt,
  input logic [CNT_W-1:0] prog_cnt,
  input slv_state_e       state
);
  AST_HOLD_RELEASES_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act_i |=> !sda_oe_o); // R11

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o) && !$past(rst_act_i)) |-> !$past(scl_s)); // R13

  AST_PROG_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_evt)); // R4

  AST_PROG_SURVIVES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_act_i && prog_cnt > CNT_W'(1)) |=> busy_o); // R12

  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state == ST_DEV) |-> !sda_oe_o); // R5
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rst_act_i(rst_act_i),
  .sda_oe_o (sda_oe_o),
  .busy_o   (busy_o),
  .scl_s    (scl_s),
  .stop_evt (stop_evt),
  .prog_cnt (prog_cnt),
  .state    (state)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int PROG       = 400;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0, hold = 1'b0;
  logic sda_oe, busy, sda_line;
  int   n_chk = 0, n_bad = 0, viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_mem [256];

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_slave #(.PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wp_i(wp), .rst_act_i(hold), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  // R13 monitor: enable must not move while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && !hold && scl && sda_oe !== prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2*Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    sda_m = ~give_ack; tick(2*Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] first, input string req);
    logic ack;
    bus_start;
    send_byte(DEV_W, ack); check("R1", "write dev ack", ack, 1);
    send_byte(a, ack);     check("R2", "word ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [3:0] lo;
      send_byte(8'(first + i), ack); check(req, "data ack", ack, 1);
      lo = a[3:0] + 4'(i);
      exp_mem[{a[7:4], lo}] = 8'(first + i);
    end
    bus_stop;
  endtask

  task automatic wait_prog;
    tick(PROG + 20);
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(DEV_W, ack); check(req, "dummy dev ack", ack, 1);
    send_byte(a, ack);     check(req, "dummy word ack", ack, 1);
    bus_start;
    send_byte(DEV_R, ack); check(req, "read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n-1);
      check(req, $sformatf("read @%0h", 8'(a + i)), d, exp_mem[8'(a + i)]);
    end
    bus_stop;
  endtask

  task automatic cur_read(input logic [7:0] a, input string req);
    logic ack;
    logic [7:0] d;
    bus_start;
    send_byte(DEV_R, ack); check(req, "cur dev ack", ack, 1);
    recv_byte(d, 1'b0);
    check(req, $sformatf("cur read @%0h", a), d, exp_mem[a]);
    bus_stop;
  endtask

  task automatic t_reset;
    check("R14", "sda_oe after reset", sda_oe, 0);
    check("R14", "busy after reset", busy, 0);
  endtask

  task automatic t_byte_write;
    do_write(8'h10, 1, 8'h5A, "R2");
    tick(2); check("R5", "busy after stop", busy, 1);
    tick(PROG - 40); check("R5", "busy near end", busy, 1);
    tick(80); check("R5", "busy cleared", busy, 0);
    do_read(8'h10, 1, "R7");
  endtask

  task automatic t_ack_poll;
    logic ack;
    do_write(8'h11, 1, 8'h66, "R2");
    bus_start; send_byte(DEV_W, ack); bus_stop;
    check("R5", "no ack while programming", ack, 0);
    wait_prog;
    bus_start; send_byte(DEV_W, ack); bus_stop;
    check("R5", "ack after programming", ack, 1);
    check("R4", "no program after empty stop", busy, 0);
  endtask

  task automatic t_page_and_cur;
    do_write(8'h31, 1, 8'hC3, "R2"); wait_prog;
    do_write(8'h23, 18, 8'h80, "R3"); wait_prog;
    do_read(8'h20, 17, "R3");
    cur_read(8'h31, "R6");
  endtask

  task automatic t_seq_wrap;
    do_write(8'hFF, 1, 8'hE1, "R2"); wait_prog;
    do_write(8'h00, 1, 8'h0F, "R2"); wait_prog;
    do_read(8'hFE, 3, "R8");
    cur_read(8'h01, "R8");
  endtask

  task automatic t_master_nack;
    logic ack;
    logic [7:0] d;
    int driven = 0;
    bus_start;
    send_byte(DEV_W, ack); send_byte(8'h10, ack);
    bus_start;
    send_byte(DEV_R, ack);
    recv_byte(d, 1'b0);
    check("R9", "byte before nack", d, exp_mem[8'h10]);
    for (int i = 0; i < 9; i++) begin
      tick(2*Q); scl = 1'b1; tick(Q);
      if (sda_oe) driven++;
      tick(Q); scl = 1'b0;
    end
    check("R9", "slave silent after nack", driven, 0);
    tick(Q);
    bus_stop;
  endtask

  task automatic t_wrong_dev;
    logic ack;
    bus_start; send_byte(8'hB0, ack); bus_stop;
    check("R1", "foreign device nibble", ack, 0);
  endtask

  task automatic t_write_protect;
    logic ack;
    wp = 1'b1;
    bus_start;
    send_byte(DEV_W, ack); check("R10", "dev ack under wp", ack, 1);
    send_byte(8'h40, ack); check("R10", "word ack under wp", ack, 1);
    send_byte(8'h77, ack); check("R10", "data nack under wp", ack, 0);
    bus_stop;
    tick(4); check("R10", "no programming under wp", busy, 0);
    wp = 1'b0;
    do_read(8'h40, 1, "R10");
  endtask

  task automatic t_empty_stop;
    logic ack;
    do_write(8'h50, 1, 8'h3C, "R2"); wait_prog;
    bus_start; send_byte(DEV_W, ack); send_byte(8'h50, ack); bus_stop;
    tick(4); check("R4", "stop after word only", busy, 0);
    cur_read(8'h50, "R6");
  endtask

  task automatic t_hold_abort;
    logic ack;
    bus_start;
    send_byte(DEV_W, ack); send_byte(8'h60, ack);
    send_byte(8'h99, ack); check("R11", "data ack before hold", ack, 1);
    hold = 1'b1; tick(3);
    check("R11", "sda released under hold", sda_oe, 0);
    bus_stop; tick(4);
    check("R11", "aborted write not programmed", busy, 0);
    bus_start; send_byte(DEV_W, ack); bus_stop;
    check("R11", "no ack under hold", ack, 0);
    hold = 1'b0; tick(5);
    do_read(8'h60, 1, "R11");
  endtask

  task automatic t_hold_prog;
    do_write(8'h70, 1, 8'h44, "R2");
    hold = 1'b1; tick(100);
    check("R12", "busy kept under hold", busy, 1);
    tick(PROG); check("R12", "countdown ends under hold", busy, 0);
    hold = 1'b0; tick(5);
    do_read(8'h70, 1, "R12");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    tick(3); rst_n = 1'b1; tick(3);
    t_reset;
    t_byte_write;
    t_ack_poll;
    t_page_and_cur;
    t_seq_wrap;
    t_master_nack;
    t_wrong_dev;
    t_write_protect;
    t_empty_stop;
    t_hold_abort;
    t_hold_prog;
    check("R13", "enable moved while scl high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule